// File: doc/BRIEF.md
# Sleep and Wake-Up Sequencer

This block moves a small processor core into a halted low-power state and brings it back out. The core's decoder raises a strobe while a sleep instruction is executing. At the end of that instruction cycle the sequencer decides what happens next.

- If an enabled interrupt is already pending, the sleep acts as a no-op.
- Otherwise the core enters the halt state. The power-down status bit is cleared, the timeout status bit is set, the watchdog receives a clear pulse, the oscillator is switched off and the core is stalled.

While halted, an enabled interrupt wakes the core, and so does a watchdog timeout when the watchdog is enabled. The global interrupt enable does not gate wake-up. It only selects what happens after the core resumes:

- With the global enable clear, the core carries on in line.
- With it set, the instruction after the sleep executes first. A dummy cycle then follows, during which the core is asked to redirect to the interrupt vector.

In crystal oscillator modes, resumption waits for a start-up interval of `OST_CYCLES` oscillator clocks. In RC mode the core resumes without that wait. The block is clocked by the oscillator input. One instruction cycle is four clocks, and the current phase is exported.

Top module: `sw_sleep_ctrl`

## Requirements
- R1: A synchronous reset sets pd_o=1 and to_o=1, turns osc_run_o and core_run_o on, clears dummy_cycle_o and vector_req_o, and sets phase_o to 0.
- R2: When sleep_exec_i is high on a clock where phase_o=3, the core is running normally, and no interrupt has both its irq_en_i and irq_flag_i bits set, the next clock shows pd_o=0, to_o=1, osc_run_o=0 and core_run_o=0. On that same clock wdt_clear_o and sleep_entry_o are high, and each stays high for exactly one clock.
- R3: If an interrupt with both its enable and flag bits set is pending when the sleep is sampled, nothing changes: pd_o, to_o and core_run_o keep their values, and no wdt_clear_o or sleep_entry_o pulse occurs.
- R4: While halted, the core stays halted when an interrupt flag is set without its enable, and when wdt_timeout_i is high while wdt_enable_i is low.
- R5: While halted, a set enable-and-flag pair wakes the core and leaves to_o unchanged. wdt_timeout_i together with wdt_enable_i wakes the core and clears to_o. Both behaviours hold whatever the value of gie_i.
- R6: A wake turns osc_run_o on at the next clock. With osc_xtal_i=0, core_run_o also rises at that next clock. With osc_xtal_i=1, core_run_o stays low for OST_CYCLES clocks after the wake clock and then rises.
- R7: If gie_i was high at the wake clock, the first resumed instruction cycle (4 clocks) runs with dummy_cycle_o=0. The next instruction cycle has dummy_cycle_o=1 and vector_req_o=1. After that, normal running resumes. If gie_i was low, neither output is raised.
- R8: A wake does not set pd_o again. Only a reset sets it.
- R9: A sleep strobe during the resumed instruction or the dummy cycle is ignored and produces no sleep_entry_o pulse.
- R10: phase_o counts 0,1,2,3 while the core runs, rests at 0 while it is stalled, and restarts from 0 on resumption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; four clocks form an instruction cycle |
| rst | input | 1 | Synchronous reset, active high |
| sleep_exec_i | input | 1 | Decoder strobe: a sleep instruction is executing |
| irq_en_i | input | IRQ_COUNT | Per-source interrupt enable bits |
| irq_flag_i | input | IRQ_COUNT | Per-source interrupt flags |
| gie_i | input | 1 | Global interrupt enable |
| wdt_enable_i | input | 1 | Watchdog enabled |
| wdt_timeout_i | input | 1 | Watchdog timeout event |
| osc_xtal_i | input | 1 | 1 = crystal mode (start-up wait), 0 = RC mode |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Timeout status bit |
| wdt_clear_o | output | 1 | One-clock watchdog and postscaler clear |
| osc_run_o | output | 1 | Oscillator driver enable |
| core_run_o | output | 1 | 1 = core runs, 0 = core stalled |
| dummy_cycle_o | output | 1 | Current instruction cycle is a dummy cycle |
| vector_req_o | output | 1 | Request to redirect fetch to address 0004h |
| sleep_entry_o | output | 1 | One-clock pulse on entry to the halt state |
| phase_o | output | 2 | Current phase within the instruction cycle |

## Verification
The assertions assume the following about the inputs:

- The sleep strobe is meaningful only at the last phase of an instruction cycle.
- A watchdog timeout is the only legitimate cause of the timeout bit falling.
- Reset is held across the first clock.

The stimulus keeps to these assumptions. It drives every input at the falling edge, and it raises the sleep strobe only after observing phase_o=3. Wake events are applied only while the core is halted, and are removed one clock later. Random choices cover the pending-before-sleep case, the wake source, the global enable and the oscillator mode.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALT,
        ST_START,
        ST_POST,
        ST_DUMMY
    } sw_state_e;

    typedef struct packed {
        sw_state_e state;
        logic      pd;
        logic      to;
        logic      gie_held;
        logic      wdt_clr;
        logic      entry;
    } sw_regs_t;

endpackage

// File: rtl/sw_phase_gen.sv
module sw_phase_gen #(
    parameter int PHASES = 4,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    output logic [PW-1:0] phase_o,
    output logic          last_o
);
    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (adv_i) begin
            if (phase_q == PW'(PHASES - 1)) phase_d = '0;
            else                            phase_d = phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    assign phase_o = phase_q;
    assign last_o  = (phase_q == PW'(PHASES - 1));

    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> phase_q == $past(phase_q));

    assert_phase_step_R10: assert property (@(posedge clk) disable iff (rst)
        (adv_i && phase_q == '0) |=> phase_q == PW'(1));
endmodule

// File: rtl/sw_wake_detect.sv
module sw_wake_detect #(
    parameter int IRQ_COUNT = 3
) (
    input  logic [IRQ_COUNT-1:0] irq_en_i,
    input  logic [IRQ_COUNT-1:0] irq_flag_i,
    input  logic                 wdt_enable_i,
    input  logic                 wdt_timeout_i,
    output logic                 irq_pend_o,
    output logic                 wdt_wake_o,
    output logic                 any_wake_o
);
    logic [IRQ_COUNT-1:0] armed;

    for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_src
        assign armed[i] = irq_en_i[i] & irq_flag_i[i];
    end

    assign irq_pend_o = |armed;
    assign wdt_wake_o = wdt_enable_i & wdt_timeout_i;
    assign any_wake_o = irq_pend_o | wdt_wake_o;
endmodule

// File: rtl/sw_startup_timer.sv
module sw_startup_timer #(
    parameter int OST_CYCLES = 1024,
    localparam int CW = (OST_CYCLES > 2) ? $clog2(OST_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && !done_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == CW'(OST_CYCLES - 1));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(OST_CYCLES - 1));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/sw_sleep_ctrl.sv
module sw_sleep_ctrl
    import sw_pkg::*;
#(
    parameter int IRQ_COUNT  = 3,
    parameter int OST_CYCLES = 1024,
    parameter int PHASES     = 4,
    localparam int PW = $clog2(PHASES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep_exec_i,
    input  logic [IRQ_COUNT-1:0] irq_en_i,
    input  logic [IRQ_COUNT-1:0] irq_flag_i,
    input  logic                 gie_i,
    input  logic                 wdt_enable_i,
    input  logic                 wdt_timeout_i,
    input  logic                 osc_xtal_i,
    output logic                 pd_o,
    output logic                 to_o,
    output logic                 wdt_clear_o,
    output logic                 osc_run_o,
    output logic                 core_run_o,
    output logic                 dummy_cycle_o,
    output logic                 vector_req_o,
    output logic                 sleep_entry_o,
    output logic [PW-1:0]        phase_o
);
    localparam sw_regs_t RESET_VAL = '{state: ST_RUN, pd: 1'b1, to: 1'b1,
                                       gie_held: 1'b0, wdt_clr: 1'b0, entry: 1'b0};

    sw_regs_t r_d, r_q;
    logic irq_pend, wdt_wake, any_wake;
    logic last_phase, ost_done, core_adv;

    sw_wake_detect #(.IRQ_COUNT(IRQ_COUNT)) u_wake (
        .irq_en_i      (irq_en_i),
        .irq_flag_i    (irq_flag_i),
        .wdt_enable_i  (wdt_enable_i),
        .wdt_timeout_i (wdt_timeout_i),
        .irq_pend_o    (irq_pend),
        .wdt_wake_o    (wdt_wake),
        .any_wake_o    (any_wake)
    );

    assign core_adv = (r_q.state == ST_RUN) || (r_q.state == ST_POST) ||
                      (r_q.state == ST_DUMMY);

    sw_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (core_adv),
        .phase_o (phase_o),
        .last_o  (last_phase)
    );

    sw_startup_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .clk    (clk),
        .rst    (rst),
        .run_i  (r_q.state == ST_START),
        .done_o (ost_done)
    );

    always_comb begin
        r_d         = r_q;
        r_d.wdt_clr = 1'b0;
        r_d.entry   = 1'b0;
        case (r_q.state)
            ST_RUN: begin
                if (sleep_exec_i && last_phase && !irq_pend) begin
                    r_d.state   = ST_HALT;
                    r_d.pd      = 1'b0;
                    r_d.to      = 1'b1;
                    r_d.wdt_clr = 1'b1;
                    r_d.entry   = 1'b1;
                end
            end
            ST_HALT: begin
                if (any_wake) begin
                    if (wdt_wake) r_d.to = 1'b0;
                    r_d.gie_held = gie_i;
                    if (osc_xtal_i)  r_d.state = ST_START;
                    else if (gie_i)  r_d.state = ST_POST;
                    else             r_d.state = ST_RUN;
                end
            end
            ST_START: begin
                if (ost_done) r_d.state = r_q.gie_held ? ST_POST : ST_RUN;
            end
            ST_POST: begin
                if (last_phase) r_d.state = ST_DUMMY;
            end
            ST_DUMMY: begin
                if (last_phase) r_d.state = ST_RUN;
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= RESET_VAL;
        else     r_q <= r_d;
    end

    assign pd_o          = r_q.pd;
    assign to_o          = r_q.to;
    assign wdt_clear_o   = r_q.wdt_clr;
    assign sleep_entry_o = r_q.entry;
    assign osc_run_o     = (r_q.state != ST_HALT);
    assign core_run_o    = core_adv;
    assign dummy_cycle_o = (r_q.state == ST_DUMMY);
    assign vector_req_o  = (r_q.state == ST_DUMMY);

    assert_pd_falls_on_entry_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(r_q.pd) |-> r_q.entry && r_q.wdt_clr);

    assert_entry_halts_R2: assert property (@(posedge clk) disable iff (rst)
        r_q.entry |-> (r_q.state == ST_HALT) && !r_q.pd && r_q.to);

    assert_entry_single_R2: assert property (@(posedge clk) disable iff (rst)
        r_q.entry |=> !r_q.entry);

    assert_noop_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_RUN && last_phase && sleep_exec_i && irq_pend)
        |=> (r_q.state == ST_RUN) && $stable(r_q.pd) && $stable(r_q.to));

    assert_to_falls_on_wdt_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(r_q.to) |-> $past(wdt_timeout_i && wdt_enable_i));

    assert_pd_never_rises_R8: assert property (@(posedge clk) disable iff (rst)
        !$rose(r_q.pd));

    assert_dummy_follows_post_R7: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_POST && last_phase) |=> r_q.state == ST_DUMMY);

    assert_no_entry_outside_run_R9: assert property (@(posedge clk) disable iff (rst)
        (r_q.state != ST_RUN) |=> !r_q.entry);
endmodule

// File: tb/sw_sleep_ctrl_test.sv
module sw_sleep_ctrl_test;
    localparam int N   = 3;
    localparam int OST = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_exec_i = 1'b0;
    logic [N-1:0] irq_en_i = '0;
    logic [N-1:0] irq_flag_i = '0;
    logic gie_i = 1'b0, wdt_enable_i = 1'b0, wdt_timeout_i = 1'b0, osc_xtal_i = 1'b0;
    logic pd_o, to_o, wdt_clear_o, osc_run_o, core_run_o, dummy_cycle_o;
    logic vector_req_o, sleep_entry_o;
    logic [1:0] phase_o;

    int checks = 0;
    int errors = 0;
    logic m_pd = 1'b1;
    logic m_to = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sw_sleep_ctrl #(.IRQ_COUNT(N), .OST_CYCLES(OST)) uut (
        .clk(clk), .rst(rst), .sleep_exec_i(sleep_exec_i),
        .irq_en_i(irq_en_i), .irq_flag_i(irq_flag_i), .gie_i(gie_i),
        .wdt_enable_i(wdt_enable_i), .wdt_timeout_i(wdt_timeout_i),
        .osc_xtal_i(osc_xtal_i), .pd_o(pd_o), .to_o(to_o),
        .wdt_clear_o(wdt_clear_o), .osc_run_o(osc_run_o), .core_run_o(core_run_o),
        .dummy_cycle_o(dummy_cycle_o), .vector_req_o(vector_req_o),
        .sleep_entry_o(sleep_entry_o), .phase_o(phase_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic exp_to_after_wake(input int kind, input logic prev);
        return (kind != 0) ? 1'b0 : prev;
    endfunction

    function automatic logic exp_stall_after_wake(input logic xtal);
        return xtal;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        m_pd = 1'b1; m_to = 1'b1;
        chk("R1 pd", pd_o, 1); chk("R1 to", to_o, 1);
        chk("R1 osc", osc_run_o, 1); chk("R1 core", core_run_o, 1);
        chk("R1 dummy", dummy_cycle_o, 0); chk("R1 vector", vector_req_o, 0);
        chk("R1 phase", phase_o, 0);
    endtask

    // kind: 0 interrupt wake, 1 watchdog wake, 2 both
    task automatic run_case(input bit pre, input int kind, input bit g, input bit x, input int idx);
        osc_xtal_i = x;
        while (phase_o != 2'd3) tick();
        sleep_exec_i = 1'b1;
        if (pre) begin irq_en_i[idx] = 1'b1; irq_flag_i[idx] = 1'b1; end
        tick();
        sleep_exec_i = 1'b0;
        if (pre) begin
            chk("R3 pd", pd_o, m_pd); chk("R3 to", to_o, m_to);
            chk("R3 core", core_run_o, 1); chk("R3 entry", sleep_entry_o, 0);
            chk("R3 wdtclr", wdt_clear_o, 0);
            irq_en_i = '0; irq_flag_i = '0;
            return;
        end
        m_pd = 1'b0; m_to = 1'b1;
        chk("R2 pd", pd_o, m_pd); chk("R2 to", to_o, m_to);
        chk("R2 entry", sleep_entry_o, 1); chk("R2 wdtclr", wdt_clear_o, 1);
        chk("R2 osc", osc_run_o, 0); chk("R2 core", core_run_o, 0);
        tick();
        chk("R2 entry pulse", sleep_entry_o, 0); chk("R2 wdtclr pulse", wdt_clear_o, 0);
        chk("R10 phase rest", phase_o, 0);
        // disabled sources must not wake
        irq_flag_i[idx] = 1'b1; irq_en_i = '0;
        wdt_timeout_i = 1'b1; wdt_enable_i = 1'b0;
        tick(); tick();
        chk("R4 core", core_run_o, 0); chk("R4 osc", osc_run_o, 0);
        irq_flag_i = '0; wdt_timeout_i = 1'b0;
        // wake
        gie_i = g;
        if (kind != 1) begin irq_en_i[idx] = 1'b1; irq_flag_i[idx] = 1'b1; end
        if (kind != 0) begin wdt_enable_i = 1'b1; wdt_timeout_i = 1'b1; end
        tick();
        irq_en_i = '0; irq_flag_i = '0; wdt_enable_i = 1'b0; wdt_timeout_i = 1'b0;
        gie_i = ~g;
        m_to = exp_to_after_wake(kind, m_to);
        chk("R5 to", to_o, m_to); chk("R6 osc", osc_run_o, 1);
        chk("R8 pd", pd_o, 0);
        chk("R6 core", core_run_o, !exp_stall_after_wake(x));
        if (x) begin
            repeat (OST - 1) tick();
            chk("R6 startup hold", core_run_o, 0);
            tick();
            chk("R6 startup end", core_run_o, 1);
        end
        chk("R10 phase restart", phase_o, 0);
        chk("R7 post", dummy_cycle_o, 0);
        repeat (3) tick();
        chk("R10 phase count", phase_o, 3);
        chk("R7 post end", dummy_cycle_o, 0);
        tick();
        chk("R7 dummy", dummy_cycle_o, g); chk("R7 vector", vector_req_o, g);
        repeat (3) tick();
        chk("R7 dummy last", dummy_cycle_o, g);
        if (g) sleep_exec_i = 1'b1;
        tick();
        sleep_exec_i = 1'b0;
        chk("R7 back", dummy_cycle_o, 0);
        chk("R9 entry", sleep_entry_o, 0); chk("R9 core", core_run_o, 1);
        chk("R8 pd kept", pd_o, 0);
        gie_i = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(20240613);
        tick();
        do_reset();
        run_case(1'b1, 0, 1'b0, 1'b0, 0);
        run_case(1'b0, 1, 1'b1, 1'b1, 1);
        run_case(1'b0, 0, 1'b0, 1'b0, 2);
        run_case(1'b0, 0, 1'b1, 1'b0, 0);
        run_case(1'b1, 0, 1'b0, 1'b0, 2);
        do_reset();
        for (int n = 0; n < 30; n++) begin
            run_case(($urandom % 4) == 0, int'($urandom % 3), 1'($urandom % 2),
                     1'($urandom % 2), int'($urandom % N));
            if ((n % 8) == 7) do_reset();
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule